// File: doc/BRIEF.md
# Programmable Match-Reset Clock Divider

This block divides an input clock by an integer ratio N taken from an 8-bit word, for any N from 1 to 255. A synchronous binary up-counter advances on each enabled input-clock cycle. Its value is compared bit by bit against the active ratio. When every bit agrees, a clear strobe is raised for exactly one input-clock cycle and returns the counter to one. That strobe is also the divided output, so the output is a short pulse rather than a square wave.

The ratio word is sampled into an active-ratio register only when a match occurs, so a new ratio first applies to the period that starts after the next output pulse. A ratio of zero is treated as one. The enable input freezes the counter and holds the output low while it is deasserted. The counter value is brought out so that the phase within the current period can be observed.

Top module: `match_divider`

## Requirements
- R1: For an active ratio N of 2 to 255, with enable held high, divOut is high for exactly one cycle in every N input-clock cycles, so the distance between consecutive pulses is N.
- R2: The count output steps through 1, 2, ..., N within each period and never exceeds the active ratio.
- R3: In the enabled cycle after count equals the active ratio on every bit, count returns to 1 and divOut is high in that same cycle.
- R4: With an active ratio of 1 and enable high, divOut is high on every cycle, so it follows enable.
- R5: A ratio word of 0 behaves exactly like a ratio of 1.
- R6: A change of the ratio word between pulses does not alter the current period; the new ratio takes effect from the pulse that ends that period.
- R7: While enable is low, count holds its value and divOut is low.
- R8: Asynchronous reset (rstN low) forces count to 0, divOut to 0 and the active ratio to 1, so the first pulse appears on the second enabled clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advance enable; low freezes counting and silences the output |
| ratio | input | 8 | Division ratio N (0 treated as 1) |
| divOut | output | 1 | Divided clock, one input-clock cycle high per period |
| count | output | 8 | Current counter value |

## Verification
The divider is run from reset with ratios 1, 2, 3, 5, 7, 128 and 255 plus the zero word; the odd ratios separate a true equality match from a toggle scheme, while the extreme ratios expose off-by-one and width errors in the period and the peak count. A ratio change placed mid-period tells an immediate reload apart from one deferred to the match. Enable is dropped during a long period and during ratio 1, showing whether the counter freezes and whether the output follows enable, and the first cycles after reset show the initial active ratio.

// File: rtl/match_divider_pkg.sv
package match_divider_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
    logic loadRatio;
  } divStrobe_t;
endpackage

// File: rtl/match_divider_datapath.sv
module match_divider_datapath
  import match_divider_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [WIDTH-1:0] ratioIn,
  input  divStrobe_t       strobe,
  output logic             matchN,
  output logic [WIDTH-1:0] countOut
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] activeQ;
  logic [WIDTH-1:0] bitEq;
  logic [WIDTH-1:0] effRatio;

  for (genvar b = 0; b < WIDTH; b++) begin : g_cmp
    assign bitEq[b] = ~(countQ[b] ^ activeQ[b]);
  end

  assign matchN   = ~&bitEq;
  assign effRatio = (ratioIn == '0) ? ONE : ratioIn;
  assign countOut = countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      activeQ <= ONE;
    end else begin
      if (strobe.clear)        countQ <= ONE;
      else if (strobe.advance) countQ <= countQ + ONE;
      if (strobe.loadRatio)    activeQ <= effRatio;
    end
  end

  assert_clear_after_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !matchN) |=> (countQ == ONE));
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= activeQ);
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(countQ));
  assert_ratio_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && matchN) |=> $stable(activeQ));
  assert_ratio_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    activeQ != '0);
endmodule

// File: rtl/match_divider_control.sv
module match_divider_control
  import match_divider_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       matchN,
  output divStrobe_t strobe,
  output logic       pulseOut
);
  logic hit;
  logic pulseQ;

  assign hit              = enable & ~matchN;
  assign strobe.clear     = hit;
  assign strobe.loadRatio = hit;
  assign strobe.advance   = enable & matchN;
  assign pulseOut         = pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= hit;
  end

  assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pulseQ);
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ && enable && matchN) |=> !pulseQ);
endmodule

// File: rtl/match_divider.sv
module match_divider
  import match_divider_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [WIDTH-1:0] ratio,
  output logic             divOut,
  output logic [WIDTH-1:0] count
);
  divStrobe_t strobe;
  logic       matchN;

  match_divider_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .ratioIn(ratio),
    .strobe(strobe), .matchN(matchN), .countOut(count)
  );

  match_divider_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .matchN(matchN),
    .strobe(strobe), .pulseOut(divOut)
  );

  assert_pulse_at_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    divOut |-> (count == WIDTH'(1)));
endmodule

// File: tb/match_divider_test.sv
module match_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // each entry: {ratio word, expected period}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd3, 8'd3}, {8'd5, 8'd5}, {8'd1, 8'd1}, {8'd0, 8'd1},
    {8'd255, 8'd255}, {8'd2, 8'd2}, {8'd128, 8'd128}, {8'd7, 8'd7}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [7:0] ratio = 8'd0;
  logic divOut;
  logic [7:0] count;
  int errors = 0;
  int checks = 0;

  match_divider uut (.clk(clk), .rstN(rstN), .enable(enable), .ratio(ratio),
                     .divOut(divOut), .count(count));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset(input logic [7:0] r);
    @(negedge clk);
    rstN = 1'b0; ratio = r; enable = 1'b1;
    tick(); tick();
    rstN = 1'b1;
  endtask

  // wait until the next sampled cycle with divOut high; returns cycles waited
  task automatic nextPulse(output int gap, output int peak);
    gap = 0; peak = 0;
    do begin
      tick(); gap++;
      if (!divOut && int'(count) > peak) peak = int'(count);
    end while (!divOut && gap < 600);
    if (int'(count) > peak) peak = int'(count);
  endtask

  initial begin
    int gap, peak, held;
    // R8 reset state and first pulse timing
    @(negedge clk);
    check("R8 reset count", int'(count), 0);
    check("R8 reset divOut", int'(divOut), 0);
    ratio = 8'd4; enable = 1'b1;
    tick();
    rstN = 1'b1;
    tick();
    check("R8 count after first edge", int'(count), 1);
    check("R8 no pulse on first edge", int'(divOut), 0);
    tick();
    check("R8 pulse on second edge", int'(divOut), 1);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      doReset(VEC[i][15:8]);
      nextPulse(gap, peak);
      nextPulse(gap, peak);
      nextPulse(gap, peak);
      check("R1 period", gap, int'(VEC[i][7:0]));
      check("R2 peak count", peak, int'(VEC[i][7:0]));
      check("R3 count at pulse", int'(count), 1);
    end

    // R4 / R5: ratio 1 and 0 keep output high every cycle and follow enable
    doReset(8'd0);
    tick(); tick(); tick();
    check("R5 zero ratio high", int'(divOut), 1);
    tick();
    check("R4 high every cycle", int'(divOut), 1);
    enable = 1'b0;
    tick();
    check("R4 follows enable low", int'(divOut), 0);
    enable = 1'b1;
    tick();
    check("R4 follows enable high", int'(divOut), 1);

    // R6: change ratio mid-period
    doReset(8'd5);
    nextPulse(gap, peak);
    nextPulse(gap, peak);
    tick();
    ratio = 8'd3;
    nextPulse(gap, peak);
    check("R6 old ratio kept", gap + 1, 5);
    nextPulse(gap, peak);
    check("R6 new ratio applied", gap, 3);

    // R7: enable low freezes count and silences output
    doReset(8'd9);
    nextPulse(gap, peak);
    tick(); tick();
    held = int'(count);
    enable = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R7 count held", int'(count), held);
      check("R7 output low", int'(divOut), 0);
    end
    enable = 1'b1;
    nextPulse(gap, peak);
    check("R7 resume remainder", gap, 9 - held + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule